// File: doc/BRIEF.md
# Stop-State Wake-to-Reset Controller

This block watches an eight-pin input port while the chip sleeps in its low-power stop state. A qualifying level change on any watched pin during stop emits a single-cycle wake strobe that carries no vector. A full system reset follows automatically. Once that reset is released, the core is held back until a long oscillator-settling count has run out. Outside stop the pins have no wake or reset effect.

Each pin first passes through a two-flop synchronizer. It then passes through a glitch filter that accepts a new level only after the level has held for a set number of consecutive samples, so short spikes are dropped. Each pin has its own active direction (rising or falling), held in an 8-bit polarity register that resets to all-falling.

A low-voltage flag overrides everything else. While it is set, the block holds the chip in a back-up state: the oscillator enable is off and reset is held. When the flag clears, the same reset-then-settle sequence runs before the core is released. Power-on reset release runs that sequence too.

Top module: `stop_wake_reset_ctrl`

## Requirements
- R1: While the core is running and `stop_i` is high, an accepted active-direction change on any one of the 8 pins makes `wake_irq_o` high for exactly one cycle. It goes high FILT_LEN+2 clock cycles after the pin changes.
- R2: While `stop_i` is low, pin changes in either direction produce no `wake_irq_o` and no `sys_rst_o`.
- R3: Polarity bit i of the register (written from `edge_sel_wd_i` when `edge_sel_we_i` is high) selects the active direction of pin i: 1 means rising and 0 means falling. The register resets to all zeros. A change in the other direction has no effect.
- R4: A pin level that differs from the filtered level for fewer than FILT_LEN consecutive samples is discarded. A level that differs for FILT_LEN consecutive samples is accepted.
- R5: In the cycle after the wake strobe, `sys_rst_o` rises. It stays high for exactly RST_CYCLES cycles (at least 4).
- R6: After `sys_rst_o` falls, `core_ready_o` stays low for exactly STAB_CYCLES cycles (default 65536) and then rises. While `rst_ni` is low, `sys_rst_o` is high and the other outputs are low except `osc_en_o`. After `rst_ni` is released, the same reset and settling sequence runs.
- R7: Pin changes during the reset or settling sequence are ignored. The sequence is neither restarted nor lengthened, and no strobe follows once the core is ready.
- R8: One cycle after `lowv_i` is seen high, `osc_en_o` is low, `sys_rst_o` is high and `core_ready_o` is low. These values persist while `lowv_i` stays high.
- R9: When `lowv_i` clears, `osc_en_o` returns high on the next cycle. The R5 reset length and the R6 settling hold then follow before `core_ready_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Active-low power-on reset |
| pins_i | input | NUM_PINS | Watched port pins (idle high) |
| stop_i | input | 1 | High while the chip is in stop state |
| lowv_i | input | 1 | Low-voltage flag, synchronous |
| edge_sel_we_i | input | 1 | Write strobe for the polarity register |
| edge_sel_wd_i | input | NUM_PINS | Polarity write data, 1 = rising |
| wake_irq_o | output | 1 | One-cycle non-vectored wake strobe |
| sys_rst_o | output | 1 | System reset, active high |
| core_ready_o | output | 1 | Core released after settling |
| osc_en_o | output | 1 | Oscillator enable, low in back-up |

## Verification
A glitch filter that is miscounted shows up as a wake strobe that comes one cycle early or late, or as a spike that triggers when it should not. Either fault is visible at `wake_irq_o` within FILT_LEN+3 cycles of the pin change. A sequencer counter that is off by one changes the measured high time of `sys_rst_o` or the low time of `core_ready_o`, and the bench measures both exactly on every wake, on back-up exit and on power-up. A sequencer that fails to ignore pins mid-sequence shows up as a lengthened sequence or a late strobe after the core is ready. A lost back-up state shows up one cycle after `lowv_i` rises, as `osc_en_o` still high.

// File: rtl/swr_pkg.sv
package swr_pkg;

  typedef enum logic [2:0] {
    ST_RUN  = 3'd0,
    ST_IRQ  = 3'd1,
    ST_RST  = 3'd2,
    ST_STAB = 3'd3,
    ST_BKUP = 3'd4
  } swr_state_e;

  // larger of two counts, used to size the shared sequence counter
  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // bits needed to hold values 0..n
  function automatic int cnt_bits(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // a filtered change counts when its new level equals the polarity bit
  function automatic logic polarity_hit(input logic new_lvl, input logic sel_rise);
    return new_lvl == sel_rise;
  endfunction

endpackage

// File: rtl/swr_pin_filter.sv
module swr_pin_filter #(
  parameter int   SYNC_STAGES = 2,
  parameter int   FILT_LEN    = 4,
  parameter logic IDLE_LVL    = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic chg_o,
  output logic nxt_o
);
  localparam int FCW = swr_pkg::cnt_bits(FILT_LEN);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   level_q;
  logic [FCW-1:0]         run_q;
  logic                   sync_out;
  logic                   differs;

  assign sync_out = sync_q[SYNC_STAGES-1];
  assign differs  = sync_out != level_q;
  assign chg_o    = differs && (run_q == FCW'(FILT_LEN - 1));
  assign nxt_o    = sync_out;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= {SYNC_STAGES{IDLE_LVL}};
      level_q <= IDLE_LVL;
      run_q   <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      if (chg_o) begin
        level_q <= sync_out;
        run_q   <= '0;
      end else if (differs) begin
        run_q <= run_q + 1'b1;
      end else begin
        run_q <= '0;
      end
    end
  end

  // R4: the filtered level only moves after the synchronized input held still
  assert_filter_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_q != $past(level_q)) |-> ($past(sync_out) == $past(sync_out, 2)));

  assert_run_bounded_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q < FCW'(FILT_LEN));

endmodule

// File: rtl/swr_seq_fsm.sv
module swr_seq_fsm #(
  parameter int RST_CYCLES  = 4,
  parameter int STAB_CYCLES = 65536
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wake_evt_i,
  input  logic lowv_i,
  output logic wake_irq_o,
  output logic sys_rst_o,
  output logic core_ready_o,
  output logic osc_en_o
);
  import swr_pkg::*;

  localparam int CW = cnt_bits(max2(RST_CYCLES, STAB_CYCLES));

  swr_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic rst_done, stab_done;

  assign rst_done  = cnt_q == CW'(RST_CYCLES - 1);
  assign stab_done = cnt_q == CW'(STAB_CYCLES - 1);

  always_comb begin
    state_d = state_q;
    cnt_d   = '0;
    unique case (state_q)
      ST_RUN:  if (wake_evt_i) state_d = ST_IRQ;
      ST_IRQ:  state_d = ST_RST;
      ST_RST:  if (rst_done) state_d = ST_STAB; else cnt_d = cnt_q + 1'b1;
      ST_STAB: if (stab_done) state_d = ST_RUN; else cnt_d = cnt_q + 1'b1;
      ST_BKUP: if (!lowv_i) state_d = ST_RST;
      default: state_d = ST_RST;
    endcase
    if (lowv_i) begin
      state_d = ST_BKUP;
      cnt_d   = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RST;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign wake_irq_o   = state_q == ST_IRQ;
  assign sys_rst_o    = (state_q == ST_RST) || (state_q == ST_BKUP);
  assign core_ready_o = state_q == ST_RUN;
  assign osc_en_o     = state_q != ST_BKUP;

  // checker counter: consecutive cycles with reset asserted, saturating
  logic [CW-1:0] rst_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_run_q <= '0;
    else if (!sys_rst_o) rst_run_q <= '0;
    else if (rst_run_q < CW'(RST_CYCLES)) rst_run_q <= rst_run_q + 1'b1;
  end

  assert_irq_strobe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_irq_o |=> !wake_irq_o);

  assert_irq_then_reset_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_irq_o |=> sys_rst_o);

  assert_reset_min_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> (rst_run_q >= CW'(RST_CYCLES)));

  assert_stab_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> !core_ready_o);

  assert_no_irq_in_seq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sys_rst_o) |-> !wake_irq_o);

  assert_backup_entry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lowv_i |=> (!osc_en_o && sys_rst_o && !core_ready_o));

  assert_backup_exit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osc_en_o && !lowv_i) |=> (osc_en_o && sys_rst_o));

endmodule

// File: rtl/stop_wake_reset_ctrl.sv
module stop_wake_reset_ctrl #(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4,
  parameter int RST_CYCLES  = 4,
  parameter int STAB_CYCLES = 65536
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                stop_i,
  input  logic                lowv_i,
  input  logic                edge_sel_we_i,
  input  logic [NUM_PINS-1:0] edge_sel_wd_i,
  output logic                wake_irq_o,
  output logic                sys_rst_o,
  output logic                core_ready_o,
  output logic                osc_en_o
);
  logic [NUM_PINS-1:0] edge_sel_q;
  logic [NUM_PINS-1:0] pin_chg;
  logic [NUM_PINS-1:0] pin_nxt;
  logic [NUM_PINS-1:0] pin_hit;
  logic                wake_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) edge_sel_q <= '0;
    else if (edge_sel_we_i) edge_sel_q <= edge_sel_wd_i;
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    swr_pin_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN),
      .IDLE_LVL   (1'b1)
    ) u_filter (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_i (pins_i[g]),
      .chg_o (pin_chg[g]),
      .nxt_o (pin_nxt[g])
    );
    assign pin_hit[g] = pin_chg[g] && swr_pkg::polarity_hit(pin_nxt[g], edge_sel_q[g]);
  end

  assign wake_evt = stop_i && (|pin_hit);

  swr_seq_fsm #(
    .RST_CYCLES (RST_CYCLES),
    .STAB_CYCLES(STAB_CYCLES)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wake_evt_i  (wake_evt),
    .lowv_i      (lowv_i),
    .wake_irq_o  (wake_irq_o),
    .sys_rst_o   (sys_rst_o),
    .core_ready_o(core_ready_o),
    .osc_en_o    (osc_en_o)
  );

  assert_no_wake_outside_stop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_irq_o |-> $past(stop_i));

  assert_wake_needs_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_irq_o |-> $past(core_ready_o));

endmodule

// File: tb/stop_wake_reset_ctrl_tb.sv
`timescale 1ns/1ps
module stop_wake_reset_ctrl_tb;
  localparam int NP = 8, FL = 4, RC = 4, SC = 40;
  localparam int FULL_SC = 65536;

  logic clk = 1'b0, rst_n = 1'b0, stop = 1'b0, lowv = 1'b0, we = 1'b0;
  logic [NP-1:0] pins = '1, wd = '0;
  logic irq, srst, ready, osc;
  logic f_irq, f_srst, f_ready, f_osc;
  int n_run = 0, n_fail = 0;
  bit full_done = 0;

  always #4 clk = ~clk;

  stop_wake_reset_ctrl #(.NUM_PINS(NP), .FILT_LEN(FL), .RST_CYCLES(RC), .STAB_CYCLES(SC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .stop_i(stop), .lowv_i(lowv),
    .edge_sel_we_i(we), .edge_sel_wd_i(wd),
    .wake_irq_o(irq), .sys_rst_o(srst), .core_ready_o(ready), .osc_en_o(osc));

  stop_wake_reset_ctrl u_full (
    .clk_i(clk), .rst_ni(rst_n), .pins_i('1), .stop_i(1'b0), .lowv_i(1'b0),
    .edge_sel_we_i(1'b0), .edge_sel_wd_i('0),
    .wake_irq_o(f_irq), .sys_rst_o(f_srst), .core_ready_o(f_ready), .osc_en_o(f_osc));

  function automatic int exp_latency(input int filt);
    return filt + 2;
  endfunction

  function automatic logic idle_level(input logic rise_sel);
    return ~rise_sel;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic write_sel(input logic [NP-1:0] v);
    @(negedge clk); we = 1'b1; wd = v;
    @(negedge clk); we = 1'b0;
  endtask

  // starts on the first reset sample; returns on the first ready sample
  task automatic seq_check(input string req);
    int hi = 0, lo = 0, bad = 0;
    while (srst && hi < 1000) begin
      if (irq || ready) bad++;
      hi++; @(negedge clk);
    end
    while (!ready && lo < 1000) begin
      if (srst || irq) bad++;
      lo++; @(negedge clk);
    end
    check(hi == RC, req, "reset length", hi, RC);
    check(lo == SC, req, "settle length", lo, SC);
    check(bad == 0, req, "stray output in sequence", bad, 0);
  endtask

  // drives pin j, returns latency to strobe (0 if none within limit)
  task automatic drive_and_wait(input int j, input logic v, input int limit, output int lat);
    lat = 0;
    @(negedge clk); pins[j] = v;
    for (int k = 1; k <= limit; k++) begin
      @(negedge clk);
      if (irq && lat == 0) lat = k;
    end
  endtask

  task automatic quiet_window(input int n, input string req);
    int seen = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (irq || srst || !ready) seen++;
    end
    check(seen == 0, req, "quiet cycles disturbed", seen, 0);
  endtask

  task automatic wake_on(input int j, input logic v, input string req);
    int lat = 0;
    @(negedge clk); pins[j] = v;
    for (int k = 1; k <= 30 && lat == 0; k++) begin
      @(negedge clk);
      if (irq) lat = k;
    end
    check(lat == exp_latency(FL), req, "wake latency", lat, exp_latency(FL));
    @(negedge clk);
    seq_check(req);
  endtask

  initial begin
    int hi = 0, lo = 0;
    wait (rst_n);
    #1;
    while (f_srst && hi < 100) begin hi++; @(negedge clk); end
    while (!f_ready && lo < 70000) begin lo++; @(negedge clk); end
    check(hi == RC, "R6", "full power-up reset", hi, RC);
    check(lo == FULL_SC, "R6", "full settle hold", lo, FULL_SC);
    full_done = 1;
  end

  initial begin
    #(8 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int lat;
    logic [NP-1:0] sel;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    // R6 reset state
    check(srst == 1'b1, "R6", "reset asserted in por", srst, 1);
    check({irq, ready} == 2'b00, "R6", "irq/ready low in por", {irq, ready}, 0);
    check(osc == 1'b1, "R6", "osc on in por", osc, 1);
    rst_n = 1'b1; #1;
    seq_check("R6");

    // R2: outside stop nothing happens
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); pins = NP'($urandom);
      repeat (3) @(negedge clk);
    end
    @(negedge clk); pins = '1;
    quiet_window(20, "R2");

    // R1, R3 random pins and polarities
    for (int it = 0; it < 5; it++) begin
      int j = $urandom % NP;
      logic p = 1'($urandom);
      sel = NP'($urandom);
      sel[j] = p;
      write_sel(sel);
      @(negedge clk); pins[j] = idle_level(p);
      quiet_window(FL + 8, "R2");
      @(negedge clk); stop = 1'b1;
      wake_on(j, p, "R1");
      @(negedge clk); stop = 1'b0; pins = '1;
      repeat (FL + 4) @(negedge clk);
    end

    // R3 wrong direction ignored, then right direction triggers
    write_sel('0 | NP'(1 << 3));
    @(negedge clk); stop = 1'b1;
    drive_and_wait(3, 1'b0, 20, lat);
    check(lat == 0 && ready, "R3", "falling on rising pin", lat, 0);
    wake_on(3, 1'b1, "R3");
    @(negedge clk); stop = 1'b0; pins = '1;
    write_sel('0);
    repeat (FL + 4) @(negedge clk);

    // R4 short pulse dropped, full-width pulse accepted
    @(negedge clk); stop = 1'b1;
    @(negedge clk); pins[5] = 1'b0;
    repeat (FL - 1) @(negedge clk);
    pins[5] = 1'b1;
    quiet_window(20, "R4");
    wake_on(5, 1'b0, "R4");

    // R7 pin activity during the sequence is ignored
    @(negedge clk); pins = '1;
    repeat (FL + 4) @(negedge clk);
    @(negedge clk); pins[1] = 1'b0;
    lat = 0;
    for (int k = 1; k <= 30 && lat == 0; k++) begin
      @(negedge clk);
      if (irq) lat = k;
    end
    check(lat == exp_latency(FL), "R1", "wake latency pin1", lat, exp_latency(FL));
    @(negedge clk);
    fork
      seq_check("R7");
      begin
        repeat (2) @(negedge clk); pins[1] = 1'b1;
        repeat (10) @(negedge clk); pins[1] = 1'b0;
        repeat (10) @(negedge clk); pins[1] = 1'b1;
      end
    join
    quiet_window(20, "R7");

    // R8, R9 low-voltage back-up
    @(negedge clk); lowv = 1'b1;
    @(negedge clk);
    check({osc, srst, ready} == 3'b010, "R8", "backup entry", {osc, srst, ready}, 3'b010);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (k == 4) pins[2] = 1'b0;
    end
    check({osc, srst, ready, irq} == 4'b0100, "R8", "backup persists", {osc, srst, ready, irq}, 4'b0100);
    lowv = 1'b0;
    @(negedge clk);
    check(osc == 1'b1, "R9", "osc back on", osc, 1);
    seq_check("R9");
    @(negedge clk); stop = 1'b0; pins = '1;

    wait (full_done);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule